// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Line Invalidate

This block sits between a processor's fetch port and a word-wide instruction memory that answers one word per request/acknowledge handshake. It keeps a direct-mapped array of lines, each holding a few instruction words plus one tag and one valid bit. A fetch that hits returns its instruction combinationally in the same cycle, so a loop held in one line runs at one instruction per cycle. A miss reads the whole line from memory, one word at a time in ascending order from the line base. The requested word goes back to the fetch port as soon as it arrives.

Two inputs force a fetch around the cache to a single memory read: a per-access inhibit flag, driven from the page attributes of the translated address, and a global enable. Such fetches neither read nor change the cache, even when the line is resident. Software drops single lines by writing an address into a write-only invalidate register. The register is selected only by the group number of the register write. The valid bits have no reset, so after power-up software must sweep every line index through the invalidate register before it turns the cache on.

With the defaults there are 512 lines of four 32-bit words. The line index is address bits [12:4] and the tag is bits [31:13].

Top module: `icache_dm`

## Requirements
- R1: After reset, with no fetch request and no register write, fetch_ack and mem_req are both 0. A sweep of invalidate writes issues no memory request.
- R2: The line index is fetch_addr[12:4] and the stored tag is fetch_addr[31:13]. A hit needs the valid bit set and a tag match. Two addresses that share an index and differ in tag evict each other.
- R3: A fetch that hits is acknowledged in the same cycle it is presented, with the stored word. Back-to-back hits complete one per cycle.
- R4: On a miss, the four words of the line are read with one memory request each, at line base +0, +4, +8 and +12 in that order. mem_addr holds steady while a request waits. Afterwards all four words hit.
- R5: During a refill, fetch_ack stays 0 until the memory acknowledges the requested word. That word is then forwarded in the same cycle. Any further fetch waits until the last word of the line has been written.
- R6: When fetch_inhibit is 1, the fetch makes exactly one memory read of its own word and returns that data. A resident line is neither used nor updated.
- R7: When cache_en is 0, every fetch behaves as in R6.
- R8: A register write with sreg_grp equal to 4 clears the valid bit of the line selected by sreg_wdata[12:4]. All other bits of sreg_wdata are ignored.
- R9: A register write with any other group number leaves the cache unchanged.
- R10: An invalidate write that arrives during a refill is held and applied on the edge that completes the refill. If it names the line being filled, that line ends invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the control state |
| cache_en | input | 1 | Global cache enable; 0 sends every fetch around the cache |
| fetch_req | input | 1 | Fetch request, held until fetch_ack |
| fetch_addr | input | 32 | Physical byte address of the instruction |
| fetch_inhibit | input | 1 | Page attribute: this access must not use the cache |
| fetch_ack | output | 1 | The fetch completes in this cycle |
| fetch_data | output | 32 | Instruction word, valid with fetch_ack |
| mem_req | output | 1 | Memory read request, held until mem_ack |
| mem_addr | output | 32 | Word-aligned memory read address |
| mem_ack | input | 1 | One-cycle pulse: mem_rdata is valid |
| mem_rdata | input | 32 | Memory read data |
| sreg_we | input | 1 | Special register write strobe |
| sreg_grp | input | 5 | Group number of the written register |
| sreg_wdata | input | 32 | Written value; bits [12:4] pick the line to invalidate |

## Verification
The fetch path is driven with four patterns, and each is told apart by its completion time in cycles and by which memory generation the returned word carries. A cold line is fetched from its first and from its third word, which separates the forwarding time of the requested word from the wait for the rest of the line. Hits after the memory contents have changed prove that the cache returned the word rather than memory. Inhibited and disabled fetches to a resident line return the new memory contents in bypass time, and the unchanged old data afterwards shows the line was left alone. Conflicting tags on one index, invalidates with junk upper bits or a foreign group number, and an invalidate that lands mid-refill are each resolved by whether the next fetch hits or misses.

// File: rtl/icache_pkg.sv
package icache_pkg;

   // Controller state of the fetch side.
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,   // lookup; hits complete here
      ST_FILL = 2'd1,   // line refill in progress
      ST_BYP  = 2'd2    // single-word read around the cache
   } icache_st_e;

endpackage

// File: rtl/icache_tag_store.sv
// Tag array plus valid bits. Neither is reset: software clears the
// valid bits through the invalidate register after power-up.
module icache_tag_store #(
   parameter int LINES = 512,
   parameter int IDX_W = 9,
   parameter int TAG_W = 19
) (
   input  logic             clk,
   input  logic [IDX_W-1:0] lk_idx,
   output logic [TAG_W-1:0] lk_tag,
   output logic             lk_valid,
   input  logic             fill_en,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             clr_a_en,
   input  logic [IDX_W-1:0] clr_a_idx,
   input  logic             clr_b_en,
   input  logic [IDX_W-1:0] clr_b_idx,
   output logic [LINES-1:0] valid_vec
);

   logic [TAG_W-1:0] tag_mem [LINES];
   logic [LINES-1:0] valid_q;

   always_ff @(posedge clk) begin
      if (fill_en) tag_mem[fill_idx] <= fill_tag;
   end

   // Clears are ordered after the fill so an invalidate wins on the
   // edge that completes a refill of the same line.
   always_ff @(posedge clk) begin
      if (fill_en)  valid_q[fill_idx]  <= 1'b1;
      if (clr_a_en) valid_q[clr_a_idx] <= 1'b0;
      if (clr_b_en) valid_q[clr_b_idx] <= 1'b0;
   end

   assign lk_tag    = tag_mem[lk_idx];
   assign lk_valid  = valid_q[lk_idx];
   assign valid_vec = valid_q;

endmodule

// File: rtl/icache_data_store.sv
// Line data, one bank per word of a line so a refill beat writes a
// single bank and a lookup reads one word combinationally.
module icache_data_store #(
   parameter int LINES      = 512,
   parameter int IDX_W      = 9,
   parameter int LINE_WORDS = 4,
   parameter int WORD_W     = 2,
   parameter int DATA_W     = 32
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [WORD_W-1:0] rd_word,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [DATA_W-1:0] wr_data
);

   logic [DATA_W-1:0] bank_out [LINE_WORDS];

   for (genvar w = 0; w < LINE_WORDS; w++) begin : g_bank
      logic [DATA_W-1:0] cells [LINES];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_word == WORD_W'(w))) cells[wr_idx] <= wr_data;
      end
      assign bank_out[w] = cells[rd_idx];
   end

   assign rd_data = bank_out[rd_word];

endmodule

// File: rtl/icache_inv_unit.sv
// Decodes invalidate writes by group number alone and defers any that
// arrive while a refill is still in flight.
module icache_inv_unit #(
   parameter int DATA_W    = 32,
   parameter int GRP_W     = 5,
   parameter int INV_GROUP = 4,
   parameter int IDX_W     = 9,
   parameter int IDX_LSB   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sreg_we,
   input  logic [GRP_W-1:0]  sreg_grp,
   input  logic [DATA_W-1:0] sreg_wdata,
   input  logic              hold,       // refill busy, not on its last edge
   output logic              now_en,
   output logic [IDX_W-1:0]  now_idx,
   output logic              late_en,
   output logic [IDX_W-1:0]  late_idx,
   output logic              pend_v
);

   logic             hit_grp;
   logic [IDX_W-1:0] sel_idx;
   logic             pend_q;
   logic [IDX_W-1:0] pend_idx_q;
   logic             unused_wdata;

   assign hit_grp      = sreg_we && (sreg_grp == GRP_W'(INV_GROUP));
   assign sel_idx      = sreg_wdata[IDX_LSB +: IDX_W];
   assign unused_wdata = ^sreg_wdata;

   assign now_en   = hit_grp && !hold;
   assign now_idx  = sel_idx;
   assign late_en  = pend_q && !hold;
   assign late_idx = pend_idx_q;
   assign pend_v   = pend_q;

   // One slot is enough: the fetch side is stalled during a refill, so
   // a later write in the same refill replaces the held one.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q     <= 1'b0;
         pend_idx_q <= '0;
      end else if (hit_grp && hold) begin
         pend_q     <= 1'b1;
         pend_idx_q <= sel_idx;
      end else if (!hold) begin
         pend_q     <= 1'b0;
      end
   end

endmodule

// File: rtl/icache_dm.sv
module icache_dm
   import icache_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINES      = 512,
   parameter int LINE_WORDS = 4,
   parameter int GRP_W      = 5,
   parameter int INV_GROUP  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cache_en,
   input  logic              fetch_req,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_inhibit,
   output logic              fetch_ack,
   output logic [DATA_W-1:0] fetch_data,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              sreg_we,
   input  logic [GRP_W-1:0]  sreg_grp,
   input  logic [DATA_W-1:0] sreg_wdata
);

   localparam int BYTE_OFS = $clog2(DATA_W / 8);
   localparam int WORD_W   = $clog2(LINE_WORDS);
   localparam int IDX_W    = $clog2(LINES);
   localparam int IDX_LSB  = BYTE_OFS + WORD_W;
   localparam int TAG_LSB  = IDX_LSB + IDX_W;
   localparam int TAG_W    = ADDR_W - TAG_LSB;
   localparam int BASE_W   = ADDR_W - IDX_LSB;

   // Elaboration-time parameter checks
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_chk_lines
      $error("LINES must be a power of two, at least 2");
   end
   if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_chk_words
      $error("LINE_WORDS must be a power of two, at least 2");
   end
   if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0) begin : g_chk_data
      $error("DATA_W must be a power of two, at least 16");
   end
   if (TAG_W < 1) begin : g_chk_tag
      $error("ADDR_W too small for LINES and LINE_WORDS");
   end
   if (DATA_W < TAG_LSB) begin : g_chk_inv
      $error("DATA_W too narrow to carry the invalidate index");
   end
   if (INV_GROUP >= (1 << GRP_W)) begin : g_chk_grp
      $error("INV_GROUP does not fit in GRP_W bits");
   end

   icache_st_e          state_q;
   logic [BASE_W-1:0]   base_q;
   logic [WORD_W-1:0]   word_q;
   logic [WORD_W-1:0]   beat_q;

   logic [IDX_W-1:0]    lk_idx;
   logic [WORD_W-1:0]   lk_word;
   logic [TAG_W-1:0]    lk_tag;
   logic                lk_valid;
   logic [DATA_W-1:0]   hit_data;
   logic                hit;
   logic                use_cache;
   logic                beat_last;
   logic                fill_done;
   logic                dwr_en;
   logic                inv_hold;
   logic                inv_now_en;
   logic [IDX_W-1:0]    inv_now_idx;
   logic                inv_late_en;
   logic [IDX_W-1:0]    inv_late_idx;
   logic                pend_v;
   logic [LINES-1:0]    valid_all;
   logic                unused_lo;

   assign lk_idx    = fetch_addr[IDX_LSB +: IDX_W];
   assign lk_word   = fetch_addr[BYTE_OFS +: WORD_W];
   assign unused_lo = ^fetch_addr[BYTE_OFS-1:0];
   assign hit       = lk_valid && (lk_tag == fetch_addr[TAG_LSB +: TAG_W]);
   assign use_cache = cache_en && !fetch_inhibit;
   assign beat_last = (beat_q == WORD_W'(LINE_WORDS - 1));
   assign inv_hold  = (state_q == ST_FILL) && !fill_done;

   icache_tag_store #(
      .LINES (LINES),
      .IDX_W (IDX_W),
      .TAG_W (TAG_W)
   ) u_tags (
      .clk       (clk),
      .lk_idx    (lk_idx),
      .lk_tag    (lk_tag),
      .lk_valid  (lk_valid),
      .fill_en   (fill_done),
      .fill_idx  (base_q[IDX_W-1:0]),
      .fill_tag  (base_q[BASE_W-1:IDX_W]),
      .clr_a_en  (inv_late_en),
      .clr_a_idx (inv_late_idx),
      .clr_b_en  (inv_now_en),
      .clr_b_idx (inv_now_idx),
      .valid_vec (valid_all)
   );

   icache_data_store #(
      .LINES      (LINES),
      .IDX_W      (IDX_W),
      .LINE_WORDS (LINE_WORDS),
      .WORD_W     (WORD_W),
      .DATA_W     (DATA_W)
   ) u_data (
      .clk     (clk),
      .rd_idx  (lk_idx),
      .rd_word (lk_word),
      .rd_data (hit_data),
      .wr_en   (dwr_en),
      .wr_idx  (base_q[IDX_W-1:0]),
      .wr_word (beat_q),
      .wr_data (mem_rdata)
   );

   icache_inv_unit #(
      .DATA_W    (DATA_W),
      .GRP_W     (GRP_W),
      .INV_GROUP (INV_GROUP),
      .IDX_W     (IDX_W),
      .IDX_LSB   (IDX_LSB)
   ) u_inv (
      .clk        (clk),
      .rst_n      (rst_n),
      .sreg_we    (sreg_we),
      .sreg_grp   (sreg_grp),
      .sreg_wdata (sreg_wdata),
      .hold       (inv_hold),
      .now_en     (inv_now_en),
      .now_idx    (inv_now_idx),
      .late_en    (inv_late_en),
      .late_idx   (inv_late_idx),
      .pend_v     (pend_v)
   );

   // Output and memory-side decode
   always_comb begin
      fetch_ack  = 1'b0;
      fetch_data = hit_data;
      mem_req    = 1'b0;
      mem_addr   = {base_q, word_q, {BYTE_OFS{1'b0}}};
      fill_done  = 1'b0;
      dwr_en     = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            fetch_ack = fetch_req && use_cache && hit;
         end
         ST_FILL: begin
            mem_req  = 1'b1;
            mem_addr = {base_q, beat_q, {BYTE_OFS{1'b0}}};
            if (mem_ack) begin
               dwr_en = 1'b1;
               if (beat_q == word_q) begin
                  fetch_ack  = 1'b1;
                  fetch_data = mem_rdata;
               end
               if (beat_last) fill_done = 1'b1;
            end
         end
         ST_BYP: begin
            mem_req = 1'b1;
            if (mem_ack) begin
               fetch_ack  = 1'b1;
               fetch_data = mem_rdata;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         base_q  <= '0;
         word_q  <= '0;
         beat_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (fetch_req && (!use_cache || !hit)) begin
                  base_q  <= fetch_addr[ADDR_W-1:IDX_LSB];
                  word_q  <= lk_word;
                  beat_q  <= '0;
                  state_q <= use_cache ? ST_FILL : ST_BYP;
               end
            end
            ST_FILL: begin
               if (mem_ack) begin
                  if (beat_last) state_q <= ST_IDLE;
                  else           beat_q  <= beat_q + WORD_W'(1);
               end
            end
            ST_BYP: begin
               if (mem_ack) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/icache_dm_sva.sv
module icache_dm_sva
   import icache_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int LINES     = 512,
   parameter int GRP_W     = 5,
   parameter int INV_GROUP = 4,
   parameter int IDX_W     = 9,
   parameter int IDX_LSB   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cache_en,
   input logic              fetch_req,
   input logic              fetch_inhibit,
   input logic              fetch_ack,
   input logic [DATA_W-1:0] fetch_data,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ack,
   input logic [DATA_W-1:0] mem_rdata,
   input logic              sreg_we,
   input logic [GRP_W-1:0]  sreg_grp,
   input logic [DATA_W-1:0] sreg_wdata,
   input icache_st_e        state,
   input logic              fill_done,
   input logic              pend_v,
   input logic [LINES-1:0]  valid_vec
);

   localparam int STEP = DATA_W / 8;

   logic inv_wr;
   assign inv_wr = sreg_we && (sreg_grp == GRP_W'(INV_GROUP));

   AST_MEM_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R4

   AST_FILL_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FILL && mem_ack && !fill_done)
         |=> (mem_addr == $past(mem_addr) + ADDR_W'(STEP))); // R4

   AST_MISS_ACK_IS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_ack && state != ST_IDLE) |-> (mem_ack && fetch_data == mem_rdata)); // R5

   AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_ack |-> fetch_req); // R5

   AST_BYPASS_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && fetch_req && (fetch_inhibit || !cache_en)) |-> !fetch_ack); // R6

   AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_wr && state != ST_FILL)
         |=> !valid_vec[$past(sreg_wdata[IDX_LSB +: IDX_W])]); // R8

   AST_INV_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_wr && state == ST_FILL && !fill_done) |=> pend_v); // R10

endmodule

bind icache_dm icache_dm_sva #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .LINES     (LINES),
   .GRP_W     (GRP_W),
   .INV_GROUP (INV_GROUP),
   .IDX_W     (IDX_W),
   .IDX_LSB   (IDX_LSB)
) u_sva (
   .clk           (clk),
   .rst_n         (rst_n),
   .cache_en      (cache_en),
   .fetch_req     (fetch_req),
   .fetch_inhibit (fetch_inhibit),
   .fetch_ack     (fetch_ack),
   .fetch_data    (fetch_data),
   .mem_req       (mem_req),
   .mem_addr      (mem_addr),
   .mem_ack       (mem_ack),
   .mem_rdata     (mem_rdata),
   .sreg_we       (sreg_we),
   .sreg_grp      (sreg_grp),
   .sreg_wdata    (sreg_wdata),
   .state         (state_q),
   .fill_done     (fill_done),
   .pend_v        (pend_v),
   .valid_vec     (valid_all)
);

// File: tb/sim_icache_dm.sv
module sim_icache_dm;

   localparam int CLK_PERIOD = 10;
   localparam int MEM_LAT    = 3;
   localparam int BYP_CYC    = MEM_LAT + 2;   // bypass / first-beat time
   localparam int BEAT_CYC   = MEM_LAT + 1;   // each further refill beat

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cache_en = 1'b1;
   logic        fetch_req = 1'b0;
   logic [31:0] fetch_addr = '0;
   logic        fetch_inhibit = 1'b0;
   logic        fetch_ack;
   logic [31:0] fetch_data;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        sreg_we = 1'b0;
   logic [4:0]  sreg_grp = '0;
   logic [31:0] sreg_wdata = '0;

   int   n_chk = 0;
   int   n_bad = 0;
   bit   finished = 1'b0;
   logic [7:0] salt = 8'h11;

   always #(CLK_PERIOD / 2) clk = ~clk;

   icache_dm u0 (
      .clk (clk), .rst_n (rst_n), .cache_en (cache_en),
      .fetch_req (fetch_req), .fetch_addr (fetch_addr),
      .fetch_inhibit (fetch_inhibit), .fetch_ack (fetch_ack),
      .fetch_data (fetch_data), .mem_req (mem_req), .mem_addr (mem_addr),
      .mem_ack (mem_ack), .mem_rdata (mem_rdata), .sreg_we (sreg_we),
      .sreg_grp (sreg_grp), .sreg_wdata (sreg_wdata)
   );

   function automatic logic [31:0] mword(input logic [31:0] a, input logic [7:0] s);
      return a ^ {s, 24'h00A5C3};
   endfunction

   // Memory model: fixed latency, one-cycle acknowledge pulse.
   int lat_cnt = 0;
   always @(posedge clk) begin
      if (mem_ack) begin
         mem_ack <= 1'b0;
      end else if (mem_req) begin
         if (lat_cnt == MEM_LAT - 1) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mword(mem_addr, salt);
            lat_cnt   <= 0;
         end else begin
            lat_cnt <= lat_cnt + 1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Scoreboard
   logic [31:0] q_data[$];
   int          q_cyc[$];
   string       q_req[$];
   int          wait_cnt = 0;

   always @(negedge clk) begin
      #2;
      if (rst_n && fetch_req) begin
         wait_cnt++;
         if (fetch_ack) begin
            if (q_data.size() == 0) begin
               check(1'b0, "R5", "unexpected ack", fetch_data, 32'h0);
            end else begin
               logic [31:0] ed;
               int ec;
               string er;
               ed = q_data.pop_front();
               ec = q_cyc.pop_front();
               er = q_req.pop_front();
               check(fetch_data === ed, er, "fetch data", fetch_data, ed);
               if (ec != 0)
                  check(wait_cnt == ec, er, "fetch cycles", wait_cnt, ec);
            end
            wait_cnt = 0;
         end
      end
   end

   task automatic fetch(input logic [31:0] a, input logic inh,
                        input logic [31:0] exp_d, input int exp_c, input string req);
      q_data.push_back(exp_d);
      q_cyc.push_back(exp_c);
      q_req.push_back(req);
      @(negedge clk);
      fetch_req     = 1'b1;
      fetch_addr    = a;
      fetch_inhibit = inh;
      forever begin
         #3;
         if (fetch_ack) break;
         @(negedge clk);
      end
   endtask

   task automatic fetch_stop();
      @(negedge clk);
      fetch_req = 1'b0;
   endtask

   task automatic sreg_write(input logic [4:0] g, input logic [31:0] v);
      @(negedge clk);
      sreg_we    = 1'b1;
      sreg_grp   = g;
      sreg_wdata = v;
      @(negedge clk);
      sreg_we    = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] s1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      // R1 reset state
      check(fetch_ack == 1'b0, "R1", "fetch_ack after reset", fetch_ack, 0);
      check(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);

      // Software sweep of every line index through the invalidate register.
      for (int i = 0; i < 512; i++) sreg_write(5'd4, i << 4);
      #2;
      check(mem_req == 1'b0, "R1", "mem_req after sweep", mem_req, 0);

      // R4/R5/R3: fill a four-instruction loop, then hits.
      s1 = salt;
      fetch(32'h140, 0, mword(32'h140, s1), BYP_CYC, "R4");
      fetch(32'h144, 0, mword(32'h144, s1), 3 * BEAT_CYC + 1, "R5");
      fetch(32'h148, 0, mword(32'h148, s1), 1, "R3");
      fetch(32'h14C, 0, mword(32'h14C, s1), 1, "R3");
      salt = 8'h22;
      for (int k = 0; k < 4; k++)
         fetch(32'h140 + 4 * k, 0, mword(32'h140 + 4 * k, s1), 1, "R3");

      // R6: inhibited fetches go to memory, line untouched.
      for (int k = 0; k < 4; k++)
         fetch(32'h140 + 4 * k, 1, mword(32'h140 + 4 * k, salt), BYP_CYC, "R6");
      fetch(32'h140, 0, mword(32'h140, s1), 1, "R6");

      // R7: global enable off behaves as bypass.
      fetch_stop();
      cache_en = 1'b0;
      fetch(32'h148, 0, mword(32'h148, salt), BYP_CYC, "R7");
      fetch_stop();
      cache_en = 1'b1;
      fetch(32'h148, 0, mword(32'h148, s1), 1, "R7");

      // R2: conflicting tag on index 0x14 evicts.
      fetch(32'h2140, 0, mword(32'h2140, salt), BYP_CYC, "R2");
      fetch(32'h2144, 0, mword(32'h2144, salt), 3 * BEAT_CYC + 1, "R2");
      fetch(32'h140, 0, mword(32'h140, salt), BYP_CYC, "R2");
      fetch(32'h14C, 0, mword(32'h14C, salt), 3 * BEAT_CYC + 1, "R2");
      fetch_stop();

      // R8: invalidate with junk upper bits, bits [12:4] = 0x14.
      sreg_write(5'd4, 32'hABCD_E140);
      salt = 8'h33;
      fetch(32'h144, 0, mword(32'h144, salt), BYP_CYC + BEAT_CYC, "R8");
      fetch(32'h140, 0, mword(32'h140, salt), 2 * BEAT_CYC + 1, "R8");
      fetch_stop();

      // R9: foreign group number has no effect.
      sreg_write(5'd3, 32'h0000_0140);
      fetch(32'h148, 0, mword(32'h148, salt), 1, "R9");

      // R5: miss on the third word of a line.
      fetch(32'h2008, 0, mword(32'h2008, salt), BYP_CYC + 2 * BEAT_CYC, "R5");
      fetch(32'h2000, 0, mword(32'h2000, salt), BEAT_CYC + 1, "R5");
      fetch_stop();

      // R10: invalidate of the line being filled, issued mid-refill.
      fork
         fetch(32'h300, 0, mword(32'h300, salt), BYP_CYC, "R10");
         begin
            repeat (2) @(negedge clk);
            sreg_write(5'd4, 32'h0000_0300);
         end
      join
      fetch(32'h304, 0, mword(32'h304, salt),
            3 * BEAT_CYC + BYP_CYC + BEAT_CYC, "R10");
      fetch(32'h308, 0, mword(32'h308, salt), 2 * BEAT_CYC + 1, "R10");
      fetch_stop();

      repeat (4) @(negedge clk);
      check(q_data.size() == 0, "R5", "outstanding fetches", q_data.size(), 0);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule